// File: doc/BRIEF.md
# Register Specifier Redirection Front End

This block sits between operand decode and the register storage of a small in-order core with sixteen architected registers. Every register specifier that an access names first passes through a binding table. A specifier without a binding reaches the ordinary register file. A bound specifier is steered to one of five small custom storage structures. Each structure holds several values behind that one name, so loop-carried values can live across iterations without widening the operand field.

Structures 0, 1 and 2 are first-in first-out queues whose reads do not consume. Structure 3 is a last-in first-out stack; a parameter can turn it into a consuming queue instead. Structure 4 is a circular buffer. A single-cycle command port binds or releases a specifier. When binding, the command also sets the active depth of the chosen structure and resets that structure's pointers. The block offers two read ports, one write port and the command port. Read data is combinational from the current state. Writes, pops and bindings take effect at the next rising clock edge.

Top module: `regmap_front`

## Requirements
- R1: After reset every specifier is unbound, every register file entry reads zero, and both flags are low.
- R2: A write to an unbound specifier stores into the register file and is visible on either read port from the next cycle. A read in the same cycle returns the old value.
- R3: A command with `map_vld_i=1`, `map_bind_i=1` and `map_sid_i` in 0..4 binds `map_spec_i` to that structure from the next cycle on. Accesses in the command cycle use the old binding. A bind with an id of 5 or more is ignored.
- R4: A write to a bound specifier goes to its structure and leaves the register file unchanged.
- R5: Structures 0..2 are queues. A write appends at the tail. A read returns the oldest entry without removing it. Reading an empty queue returns zero.
- R6: Structure 3 is a stack. A write pushes and a read pops the newest value. Reading an empty stack returns zero and raises `unf_o` in that cycle. A read and a write in the same cycle return the old top and then replace it.
- R7: Structure 4 is a circular buffer. A write stores at the write pointer, overwriting the oldest entry, and the pointer advances modulo the depth. A read returns the entry at the read pointer, and that pointer advances modulo the depth. No flag is ever raised.
- R8: Binding sets the structure depth from `map_cfg_i`. A value of 0 counts as 1, and values above 8 count as 8. Binding clears the structure's pointers and count. This clear takes priority over any access to that structure in the same cycle.
- R9: When both read ports reach the same structure in one cycle, both return the same value and at most one pop or advance happens.
- R10: A write into a full queue or stack is dropped, and `ovf_o` is high in that cycle. If a pop happens in the same cycle, the write is accepted.
- R11: A command with `map_vld_i=1` and `map_bind_i=0` releases `map_spec_i` from the next cycle on. The register file entry behind it keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| map_vld_i | input | 1 | Binding command valid |
| map_bind_i | input | 1 | 1 binds, 0 releases |
| map_spec_i | input | 4 | Specifier the command acts on |
| map_cfg_i | input | 4 | Requested depth of the structure |
| map_sid_i | input | 3 | Target structure id (0..4) |
| wr_en_i | input | 1 | Write enable |
| wr_spec_i | input | 4 | Write specifier |
| wr_data_i | input | 32 | Write data |
| rd0_en_i | input | 1 | Read port 0 enable (drives pops/advances) |
| rd0_spec_i | input | 4 | Read port 0 specifier |
| rd0_data_o | output | 32 | Read port 0 data |
| rd1_en_i | input | 1 | Read port 1 enable |
| rd1_spec_i | input | 4 | Read port 1 specifier |
| rd1_data_o | output | 32 | Read port 1 data |
| ovf_o | output | 1 | A write was dropped this cycle |
| unf_o | output | 1 | A consuming read found its structure empty |

## Verification
The steering function is exercised in four patterns. The first is plain register file traffic, which shows the bypass is transparent. The second is queue traffic up to full, which shows a non-consuming read apart from a pop and exposes the drop rule. The third is stack traffic with empty, full, dual-port and read-with-write cycles, which separates newest-first order from oldest-first order and shows a single pop from a double one. The fourth is circular buffer traffic that wraps both pointers, which shows modulo stepping apart from saturation. Commands issued in the same cycle as accesses check that bindings take effect one cycle later. Out-of-range depth values and rebinding check the clamp and the pointer clear.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  typedef enum logic [1:0] {
    K_QUEUE,
    K_DQUEUE,
    K_STACK,
    K_CIRC
  } kind_e;
endpackage

// File: rtl/regmap_rf.sv
module regmap_rf #(
  parameter int NUM_SPEC = 16,
  parameter int DATA_W   = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [$clog2(NUM_SPEC)-1:0] wa_i,
  input  logic [DATA_W-1:0]           wd_i,
  input  logic [$clog2(NUM_SPEC)-1:0] ra0_i,
  output logic [DATA_W-1:0]           rd0_o,
  input  logic [$clog2(NUM_SPEC)-1:0] ra1_i,
  output logic [DATA_W-1:0]           rd1_o
);
  logic [NUM_SPEC-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign rd0_o = mem_q[ra0_i];
  assign rd1_o = mem_q[ra1_i];

  // R4 / R11: no write enable, no change to the file
  a_r4_file_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (mem_q == $past(mem_q)));
  // R2: an enabled write lands at its address
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(wa_i)] == $past(wd_i)));
endmodule

// File: rtl/regmap_table.sv
module regmap_table #(
  parameter int NUM_SPEC   = 16,
  parameter int NUM_STRUCT = 5,
  parameter int NUM_LOOK   = 3,
  localparam int SPEC_W    = $clog2(NUM_SPEC),
  localparam int SID_W     = $clog2(NUM_STRUCT)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             map_vld_i,
  input  logic                             map_bind_i,
  input  logic [SPEC_W-1:0]                map_spec_i,
  input  logic [SID_W-1:0]                 map_sid_i,
  input  logic [NUM_LOOK-1:0][SPEC_W-1:0]  look_spec_i,
  output logic [NUM_LOOK-1:0]              hit_o,
  output logic [NUM_LOOK-1:0][SID_W-1:0]   sid_o
);
  logic [NUM_SPEC-1:0]             vld_q, vld_d;
  logic [NUM_SPEC-1:0][SID_W-1:0]  sid_q, sid_d;
  logic                            sid_ok;

  assign sid_ok = (int'(map_sid_i) < NUM_STRUCT);

  always_comb begin
    vld_d = vld_q;
    sid_d = sid_q;
    if (map_vld_i) begin
      if (!map_bind_i) begin
        vld_d[map_spec_i] = 1'b0;
      end else if (sid_ok) begin
        vld_d[map_spec_i] = 1'b1;
        sid_d[map_spec_i] = map_sid_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      sid_q <= '0;
    end else if (map_vld_i) begin
      vld_q <= vld_d;
      sid_q <= sid_d;
    end
  end

  for (genvar l = 0; l < NUM_LOOK; l++) begin : g_look
    assign hit_o[l] = vld_q[look_spec_i[l]];
    assign sid_o[l] = sid_q[look_spec_i[l]];
  end

  // R3: a valid bind is in force one cycle later
  a_r3_bind_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_vld_i && map_bind_i && sid_ok) |=>
      (vld_q[$past(map_spec_i)] && (sid_q[$past(map_spec_i)] == $past(map_sid_i))));
  // R11: a release is in force one cycle later
  a_r11_release_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_vld_i && !map_bind_i) |=> !vld_q[$past(map_spec_i)]);
endmodule

// File: rtl/regmap_struct.sv
module regmap_struct
  import regmap_pkg::*;
#(
  parameter kind_e KIND      = K_QUEUE,
  parameter int    DATA_W    = 32,
  parameter int    MAX_DEPTH = 8,
  parameter int    CFG_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] peek_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int PTR_W = $clog2(MAX_DEPTH);
  localparam int CNT_W = $clog2(MAX_DEPTH + 1);
  localparam bit POPS  = (KIND == K_DQUEUE) || (KIND == K_STACK);

  logic [MAX_DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [PTR_W-1:0] a_q, a_d, b_q, b_d, mem_wa;
  logic [CNT_W-1:0] cnt_q, cnt_d, dep_q, dep_d, base;
  logic [CNT_W:0]   tail;
  logic             mem_we, empty, full, pop, do_push;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic [CNT_W-1:0] d);
    if (CNT_W'(p) + CNT_W'(1) >= d) return '0;
    return p + PTR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] clamp(input logic [CFG_W-1:0] c);
    if (c == '0) return CNT_W'(1);
    if (int'(c) > MAX_DEPTH) return CNT_W'(MAX_DEPTH);
    return CNT_W'(c);
  endfunction

  always_comb begin
    a_d     = a_q;
    b_d     = b_q;
    cnt_d   = cnt_q;
    dep_d   = dep_q;
    mem_we  = 1'b0;
    mem_wa  = a_q;
    tail    = '0;
    base    = cnt_q;
    empty   = (cnt_q == '0);
    full    = (cnt_q == dep_q);
    pop     = rd_i && POPS && !empty;
    unf_o   = rd_i && POPS && empty;
    ovf_o   = 1'b0;
    do_push = 1'b0;
    peek_o  = '0;
    if (KIND == K_CIRC) begin
      peek_o = mem_q[a_q];
      mem_we = push_i;
      mem_wa = b_q;
      if (push_i) b_d = step(b_q, dep_q);
      if (rd_i)   a_d = step(a_q, dep_q);
    end else if (KIND == K_STACK) begin
      peek_o  = empty ? '0 : mem_q[PTR_W'(cnt_q - CNT_W'(1))];
      ovf_o   = push_i && full && !pop;
      do_push = push_i && !ovf_o;
      base    = cnt_q - CNT_W'(pop);
      mem_we  = do_push;
      mem_wa  = PTR_W'(base);
      cnt_d   = base + CNT_W'(do_push);
    end else begin
      peek_o  = empty ? '0 : mem_q[a_q];
      ovf_o   = push_i && full && !pop;
      do_push = push_i && !ovf_o;
      tail    = {1'b0, CNT_W'(a_q)} + {1'b0, cnt_q};
      if (tail >= {1'b0, dep_q}) tail = tail - {1'b0, dep_q};
      mem_we  = do_push;
      mem_wa  = PTR_W'(tail);
      if (pop) a_d = step(a_q, dep_q);
      cnt_d   = cnt_q + CNT_W'(do_push) - CNT_W'(pop);
    end
    if (clr_i) begin
      a_d    = '0;
      b_d    = '0;
      cnt_d  = '0;
      dep_d  = clamp(cfg_i);
      mem_we = 1'b0;
      ovf_o  = 1'b0;
      unf_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
      dep_q <= CNT_W'(MAX_DEPTH);
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      cnt_q <= cnt_d;
      dep_q <= dep_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (mem_we) begin
      mem_q[mem_wa] <= wdata_i;
    end
  end

  // R10: a dropped write leaves the occupancy unchanged
  a_r10_drop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == $past(cnt_q)));
  // R6: an empty consuming read delivers zero
  a_r6_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (peek_o == '0));
  // R8: a bind leaves the structure empty with pointers at zero
  a_r8_clear_pointers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((cnt_q == '0) && (a_q == '0) && (b_q == '0)));
  // R8: active depth stays within 1..MAX_DEPTH
  a_r8_depth_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dep_q != '0) && (int'(dep_q) <= MAX_DEPTH));
endmodule

// File: rtl/regmap_front.sv
module regmap_front
  import regmap_pkg::*;
#(
  parameter int    DATA_W     = 32,
  parameter int    NUM_SPEC   = 16,
  parameter int    NUM_STRUCT = 5,
  parameter int    MAX_DEPTH  = 8,
  parameter int    CFG_W      = 4,
  parameter kind_e KIND_ALT   = K_STACK,
  localparam int   SPEC_W     = $clog2(NUM_SPEC),
  localparam int   SID_W      = $clog2(NUM_STRUCT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_vld_i,
  input  logic              map_bind_i,
  input  logic [SPEC_W-1:0] map_spec_i,
  input  logic [CFG_W-1:0]  map_cfg_i,
  input  logic [SID_W-1:0]  map_sid_i,
  input  logic              wr_en_i,
  input  logic [SPEC_W-1:0] wr_spec_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd0_en_i,
  input  logic [SPEC_W-1:0] rd0_spec_i,
  output logic [DATA_W-1:0] rd0_data_o,
  input  logic              rd1_en_i,
  input  logic [SPEC_W-1:0] rd1_spec_i,
  output logic [DATA_W-1:0] rd1_data_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int LK_RD0 = 0;
  localparam int LK_RD1 = 1;
  localparam int LK_WR  = 2;

  logic [1:0]                       rst_sync_q;
  logic                             rst_int_n;
  logic [2:0][SPEC_W-1:0]           look_spec;
  logic [2:0]                       hit;
  logic [2:0][SID_W-1:0]            sid;
  logic [NUM_STRUCT-1:0]            s_push, s_rd, s_clr, s_ovf, s_unf;
  logic [NUM_STRUCT-1:0][DATA_W-1:0] s_peek;
  logic [DATA_W-1:0]                rf_rd0, rf_rd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign look_spec[LK_RD0] = rd0_spec_i;
  assign look_spec[LK_RD1] = rd1_spec_i;
  assign look_spec[LK_WR]  = wr_spec_i;

  regmap_table #(.NUM_SPEC(NUM_SPEC), .NUM_STRUCT(NUM_STRUCT), .NUM_LOOK(3)) i_table (
    .clk_i, .rst_ni(rst_int_n), .map_vld_i, .map_bind_i, .map_spec_i, .map_sid_i,
    .look_spec_i(look_spec), .hit_o(hit), .sid_o(sid));

  regmap_rf #(.NUM_SPEC(NUM_SPEC), .DATA_W(DATA_W)) i_rf (
    .clk_i, .rst_ni(rst_int_n), .we_i(wr_en_i && !hit[LK_WR]), .wa_i(wr_spec_i),
    .wd_i(wr_data_i), .ra0_i(rd0_spec_i), .rd0_o(rf_rd0), .ra1_i(rd1_spec_i), .rd1_o(rf_rd1));

  for (genvar s = 0; s < NUM_STRUCT; s++) begin : g_struct
    localparam kind_e K = (s == NUM_STRUCT - 1) ? K_CIRC :
                          (s == NUM_STRUCT - 2) ? KIND_ALT : K_QUEUE;
    assign s_push[s] = wr_en_i && hit[LK_WR] && (sid[LK_WR] == SID_W'(s));
    assign s_rd[s]   = (rd0_en_i && hit[LK_RD0] && (sid[LK_RD0] == SID_W'(s))) ||
                       (rd1_en_i && hit[LK_RD1] && (sid[LK_RD1] == SID_W'(s)));
    assign s_clr[s]  = map_vld_i && map_bind_i && (map_sid_i == SID_W'(s));
    regmap_struct #(.KIND(K), .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .CFG_W(CFG_W)) i_st (
      .clk_i, .rst_ni(rst_int_n), .clr_i(s_clr[s]), .cfg_i(map_cfg_i),
      .push_i(s_push[s]), .wdata_i(wr_data_i), .rd_i(s_rd[s]),
      .peek_o(s_peek[s]), .ovf_o(s_ovf[s]), .unf_o(s_unf[s]));
  end

  always_comb begin
    rd0_data_o = hit[LK_RD0] ? '0 : rf_rd0;
    rd1_data_o = hit[LK_RD1] ? '0 : rf_rd1;
    for (int s = 0; s < NUM_STRUCT; s++) begin
      if (hit[LK_RD0] && (sid[LK_RD0] == SID_W'(s))) rd0_data_o = s_peek[s];
      if (hit[LK_RD1] && (sid[LK_RD1] == SID_W'(s))) rd1_data_o = s_peek[s];
    end
  end

  assign ovf_o = |s_ovf;
  assign unf_o = |s_unf;

  // R9: both ports on one structure see one value
  a_r9_shared_read: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (hit[LK_RD0] && hit[LK_RD1] && (sid[LK_RD0] == sid[LK_RD1])) |->
      (rd0_data_o == rd1_data_o));
  // R1: flags stay low while no access is made
  a_r1_quiet_flags: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!wr_en_i && !rd0_en_i && !rd1_en_i) |-> (!ovf_o && !unf_o));
endmodule

// File: tb/test_regmap_front.sv
module test_regmap_front;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mv;
    logic        mb;
    logic [3:0]  ms;
    logic [3:0]  mc;
    logic [2:0]  mid;
    logic        we;
    logic [3:0]  ws;
    logic [31:0] wd;
    logic        r0e;
    logic [3:0]  r0s;
    logic        r1e;
    logic [3:0]  r1s;
    logic [31:0] e0;
    logic [31:0] e1;
    logic        eo;
    logic        eu;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  // fields: mv mb ms mc mid | we ws wd | r0e r0s r1e r1s | e0 e1 eo eu | req
  localparam vec_t VEC [NV] = '{
    '{0,0,0,0,0, 1,2,'h11,   1,2,0,0, 0,0,0,0, 2},         // R2 old value same cycle
    '{0,0,0,0,0, 0,0,0,      1,2,1,5, 'h11,0,0,0, 2},      // R2 visible next cycle
    '{1,1,3,2,0, 1,3,'hAA,   1,3,0,0, 0,0,0,0, 3},         // R3 old binding in cmd cycle
    '{0,0,0,0,0, 1,3,'h21,   1,3,0,0, 0,0,0,0, 5},         // R5 empty queue reads zero
    '{0,0,0,0,0, 1,3,'h22,   1,3,0,0, 'h21,0,0,0, 5},      // R5 oldest
    '{0,0,0,0,0, 1,3,'h23,   1,3,1,3, 'h21,'h21,1,0, 10},  // R10 full queue drop
    '{0,0,0,0,0, 0,0,0,      1,3,0,0, 'h21,0,0,0, 5},      // R5 non-consuming
    '{1,0,3,0,0, 0,0,0,      1,3,0,0, 'h21,0,0,0, 11},     // R11 release cycle
    '{0,0,0,0,0, 0,0,0,      1,3,0,0, 'hAA,0,0,0, 11},     // R11 R4 file untouched
    '{1,1,7,3,3, 0,0,0,      1,7,0,0, 0,0,0,0, 3},         // R3 bind stack
    '{0,0,0,0,0, 0,0,0,      1,7,0,0, 0,0,0,1, 6},         // R6 empty stack underflow
    '{0,0,0,0,0, 1,7,'h31,   0,0,0,0, 0,0,0,0, 6},
    '{0,0,0,0,0, 1,7,'h32,   0,0,0,0, 0,0,0,0, 6},
    '{0,0,0,0,0, 1,7,'h33,   0,0,0,0, 0,0,0,0, 6},
    '{0,0,0,0,0, 1,7,'h34,   0,0,0,0, 0,0,1,0, 10},        // R10 full stack drop
    '{0,0,0,0,0, 0,0,0,      1,7,1,7, 'h33,'h33,0,0, 9},   // R9 dual read
    '{0,0,0,0,0, 0,0,0,      1,7,0,0, 'h32,0,0,0, 9},      // R9 only one pop
    '{0,0,0,0,0, 1,7,'h40,   1,7,0,0, 'h31,0,0,0, 6},      // R6 read+write
    '{0,0,0,0,0, 0,0,0,      1,7,0,0, 'h40,0,0,0, 6},
    '{0,0,0,0,0, 0,0,0,      1,7,0,0, 0,0,0,1, 6},         // R6 empty again
    '{1,1,9,3,4, 0,0,0,      0,0,0,0, 0,0,0,0, 7},         // R7 bind circular
    '{0,0,0,0,0, 1,9,'h51,   0,0,0,0, 0,0,0,0, 7},
    '{0,0,0,0,0, 1,9,'h52,   0,0,0,0, 0,0,0,0, 7},
    '{0,0,0,0,0, 1,9,'h53,   0,0,0,0, 0,0,0,0, 7},
    '{0,0,0,0,0, 1,9,'h54,   0,0,0,0, 0,0,0,0, 7},         // R7 overwrite, no flag
    '{0,0,0,0,0, 0,0,0,      1,9,0,0, 'h54,0,0,0, 7},
    '{0,0,0,0,0, 0,0,0,      1,9,0,0, 'h52,0,0,0, 7},
    '{0,0,0,0,0, 0,0,0,      1,9,0,0, 'h53,0,0,0, 7},
    '{0,0,0,0,0, 0,0,0,      1,9,0,0, 'h54,0,0,0, 7},      // R7 read pointer wraps
    '{1,1,9,0,4, 0,0,0,      1,9,0,0, 'h52,0,0,0, 8},      // R8 rebind depth 0 -> 1
    '{0,0,0,0,0, 1,9,'h61,   1,9,0,0, 'h54,0,0,0, 8},      // R8 pointers cleared
    '{0,0,0,0,0, 0,0,0,      1,9,0,0, 'h61,0,0,0, 8},
    '{0,0,0,0,0, 0,0,0,      1,9,0,0, 'h61,0,0,0, 8}       // R8 depth one
  };

  logic        clk, rst_n;
  logic        map_vld, map_bind, wr_en, rd0_en, rd1_en, ovf, unf;
  logic [3:0]  map_spec, map_cfg, wr_spec, rd0_spec, rd1_spec;
  logic [2:0]  map_sid;
  logic [31:0] wr_data, rd0_data, rd1_data;
  int          checks = 0;
  int          errors = 0;

  regmap_front i_regmap_front (
    .clk_i(clk), .rst_ni(rst_n),
    .map_vld_i(map_vld), .map_bind_i(map_bind), .map_spec_i(map_spec),
    .map_cfg_i(map_cfg), .map_sid_i(map_sid),
    .wr_en_i(wr_en), .wr_spec_i(wr_spec), .wr_data_i(wr_data),
    .rd0_en_i(rd0_en), .rd0_spec_i(rd0_spec), .rd0_data_o(rd0_data),
    .rd1_en_i(rd1_en), .rd1_spec_i(rd1_spec), .rd1_data_o(rd1_data),
    .ovf_o(ovf), .unf_o(unf));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    string tag;
    @(negedge clk);
    map_vld = v.mv; map_bind = v.mb; map_spec = v.ms; map_cfg = v.mc; map_sid = v.mid;
    wr_en = v.we; wr_spec = v.ws; wr_data = v.wd;
    rd0_en = v.r0e; rd0_spec = v.r0s; rd1_en = v.r1e; rd1_spec = v.r1s;
    #1;
    tag = $sformatf("R%0d", v.req);
    if (v.r0e) check({tag, " rd0"}, rd0_data, v.e0);
    if (v.r1e) check({tag, " rd1"}, rd1_data, v.e1);
    check({tag, " ovf"}, {31'b0, ovf}, {31'b0, v.eo});
    check({tag, " unf"}, {31'b0, unf}, {31'b0, v.eu});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 1'b0;
    map_vld = 0; map_bind = 0; map_spec = 0; map_cfg = 0; map_sid = 0;
    wr_en = 0; wr_spec = 0; wr_data = 0;
    rd0_en = 0; rd0_spec = 0; rd1_en = 0; rd1_spec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: every specifier unbound and zero after reset
    for (int s = 0; s < 16; s++) begin
      v = '{0,0,0,0,0, 0,0,0, 1,s,1,15-s, 0,0,0,0, 1};
      apply(v);
    end

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R8: depth above eight clamps to eight
    v = '{1,1,4,15,1, 0,0,0, 0,0,0,0, 0,0,0,0, 8};
    apply(v);
    for (int i = 0; i < 8; i++) begin
      v = '{0,0,0,0,0, 1,4,32'h100 + i, 0,0,0,0, 0,0,0,0, 8};
      apply(v);
    end
    v = '{0,0,0,0,0, 1,4,'h1FF, 1,4,0,0, 'h100,0,1,0, 10};   // R10 ninth write dropped
    apply(v);
    // R8: rebind empties the queue
    v = '{1,1,4,2,1, 0,0,0, 0,0,0,0, 0,0,0,0, 8};
    apply(v);
    v = '{0,0,0,0,0, 0,0,0, 1,4,0,0, 0,0,0,0, 8};
    apply(v);
    // R3: bind to id 5 is ignored, specifier stays on the file
    v = '{1,1,6,3,5, 1,6,'h77, 0,0,0,0, 0,0,0,0, 3};
    apply(v);
    v = '{0,0,0,0,0, 0,0,0, 1,6,0,0, 'h77,0,0,0, 3};
    apply(v);
    // R4: write to bound specifier does not reach the file
    v = '{0,0,0,0,0, 1,4,'hBEEF, 0,0,0,0, 0,0,0,0, 4};
    apply(v);
    v = '{1,0,4,0,0, 0,0,0, 0,0,0,0, 0,0,0,0, 4};
    apply(v);
    v = '{0,0,0,0,0, 0,0,0, 1,4,0,0, 0,0,0,0, 4};
    apply(v);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule